// File: doc/BRIEF.md
# Capture-Compare Timer with Synchronized External Count

A 16-bit timer/counter for a microcontroller-class subsystem. Each count step comes from one of three sources: the system clock, the system clock divided by a free-running prescaler, or an external pin. The external pin is first passed through a synchronizer to the system clock and then through an edge detector. The counter runs up or down. Two compare registers each raise a status flag and toggle an output pin when they match. A capture input copies the live count into a capture register. Overflow, compare A, compare B and capture each have a sticky flag and a mask bit, and the mask bit gates that flag onto its interrupt line.

Software reaches every register through a byte-wide register port. A 16-bit value moves through a shared staging byte so that both halves of the value belong to the same instant. Reading a low byte latches the matching high byte into the staging byte. Writing a high byte only stages it, and the whole 16-bit value is committed when the low byte is written.

Top module: `cc_timer`

## Requirements
- R1: After reset, every register address reads 0x00. `irq_o`, `cmp_a_o` and `cmp_b_o` are all 0.
- R2: CTRL (address 0) bits [2:0] select the count source. The codes are: 0 = stopped, 1 = every clock, 2 = /8, 3 = /64, 4 = /256, 5 = /1024, 6 = external rising edge, 7 = external falling edge. While the source is stopped, the count keeps its value.
- R3: A divided source advances the counter on the cycles in which the low 3, 6, 8 or 10 bits of a free-running 10-bit prescaler are all ones. Writing the counter restarts the prescaler from zero.
- R4: The external pin passes through SYNC_STAGES flip-flops and then an edge detector. A qualifying edge advances the counter exactly once. With the default of 2 stages, the count changes on the third clock edge after the pin changes. Each pin level must be held for at least one clock period.
- R5: CTRL bit 3 = 1 makes the counter count down. On an advance from 0xFFFF while counting up, or from 0x0000 while counting down, the counter wraps and flag bit 0 (overflow) is set.
- R6: On an advance in which the count equals compare A (addresses 5/6), flag bit 1 is set and `cmp_a_o` toggles. Compare B (addresses 7/8) does the same with flag bit 2 and `cmp_b_o`. This includes the compare values 0x0000 and 0xFFFF.
- R7: When CTRL bit 4 = 1, an advance that matches compare A loads the counter with 0x0000 instead of the next value.
- R8: A rising edge on `cap_i` is synchronized the same way as the external pin. The edge then copies the count into the capture register (addresses 9/10, read only) and sets flag bit 3. The copied value is the count before any advance in that same cycle. If the edge lands on the wrap from 0xFFFF, the capture register holds 0xFFFF and both flag bits 3 and 0 are set.
- R9: Flags (address 1) are sticky. Writing 1 to a flag bit clears it, and a new event in the same cycle wins over the clear. `irq_o[i]` is 1 exactly when flag bit i and mask bit i (address 2) are both 1.
- R10: The counter occupies addresses 3 (low) and 4 (high). Reading any low byte latches its high byte into the staging byte, and reading any high byte returns the staging byte. A write to address 4, 6 or 8 only stages the byte. A low-byte write commits {staged, data}, and a counter write overrides any advance in that cycle. Writes to addresses 9 and 10 are ignored, and unused addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_cnt_i | input | 1 | External count pin, asynchronous |
| cap_i | input | 1 | Capture trigger pin, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 4 | Register byte address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational from the address |
| irq_o | output | 4 | Masked requests: bit 0 overflow, bit 1 compare A, bit 2 compare B, bit 3 capture |
| cmp_a_o | output | 1 | Toggles on each compare A match |
| cmp_b_o | output | 1 | Toggles on each compare B match |

## Verification
The bench drives the counter through both wrap points and places the compare registers at 0x0000 and 0xFFFF. A design whose compare misses either end would leave a flag low or a pin untoggled. A capture edge is timed to land on the very cycle of the overflow wrap. A design that samples the count after the advance would capture 0x0000 instead of 0xFFFF. External edges are spaced at the minimum distance, so a missing synchronizer stage or a level-sensitive detector shows up as a count shifted by one cycle or counted twice. Staged high bytes, prescaler restart on a counter write, and write-1-to-clear against a same-cycle event are each compared with the reference model every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int NFLAG  = 4;
  localparam int PSC_W  = 10;
  localparam int ADDR_W = 4;

  localparam int F_OVF  = 0;
  localparam int F_CMPA = 1;
  localparam int F_CMPB = 2;
  localparam int F_CAP  = 3;

  typedef enum logic [2:0] {
    SRC_STOP     = 3'd0,
    SRC_CLK      = 3'd1,
    SRC_DIV8     = 3'd2,
    SRC_DIV64    = 3'd3,
    SRC_DIV256   = 3'd4,
    SRC_DIV1024  = 3'd5,
    SRC_EXT_RISE = 3'd6,
    SRC_EXT_FALL = 3'd7
  } src_e;

  typedef struct packed {
    logic clr_a;
    logic down;
    src_e src;
  } ctrl_t;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 4'd1;
  localparam logic [ADDR_W-1:0] A_MASK   = 4'd2;
  localparam logic [ADDR_W-1:0] A_CNT_L  = 4'd3;
  localparam logic [ADDR_W-1:0] A_CNT_H  = 4'd4;
  localparam logic [ADDR_W-1:0] A_CMPA_L = 4'd5;
  localparam logic [ADDR_W-1:0] A_CMPA_H = 4'd6;
  localparam logic [ADDR_W-1:0] A_CMPB_L = 4'd7;
  localparam logic [ADDR_W-1:0] A_CMPB_H = 4'd8;
  localparam logic [ADDR_W-1:0] A_CAP_L  = 4'd9;
  localparam logic [ADDR_W-1:0] A_CAP_H  = 4'd10;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic prev_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign lvl_o  = sh_q[STAGES-1];
  assign prev_o = sh_q[STAGES];
endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
  import tmr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  src_e src_i,
  input  logic psc_clr_i,
  input  logic ext_rise_i,
  input  logic ext_fall_i,
  output logic tick_o
);
  localparam int NTAP = 4;
  localparam int TapBits [NTAP] = '{3, 6, 8, PSC_W};

  logic [PSC_W-1:0] psc_q;
  logic [NTAP-1:0]  tap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        psc_q <= '0;
    else if (psc_clr_i) psc_q <= '0;
    else                psc_q <= psc_q + 1'b1;
  end

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    assign tap[k] = &psc_q[TapBits[k]-1:0];
  end

  always_comb begin
    unique case (src_i)
      SRC_STOP:     tick_o = 1'b0;
      SRC_CLK:      tick_o = 1'b1;
      SRC_DIV8:     tick_o = tap[0];
      SRC_DIV64:    tick_o = tap[1];
      SRC_DIV256:   tick_o = tap[2];
      SRC_DIV1024:  tick_o = tap[3];
      SRC_EXT_RISE: tick_o = ext_rise_i;
      SRC_EXT_FALL: tick_o = ext_fall_i;
      default:      tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             down_i,
  input  logic             clr_a_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic [CNT_W-1:0] cmp_a_i,
  input  logic [CNT_W-1:0] cmp_b_i,
  input  logic             cap_evt_i,
  input  logic [NFLAG-1:0] flag_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cap_o,
  output logic [NFLAG-1:0] flags_o,
  output logic             cmp_a_pin_o,
  output logic             cmp_b_pin_o
);
  logic             adv, match_a, match_b, wrap;
  logic [CNT_W-1:0] cnt_nx;
  logic [NFLAG-1:0] set_v;

  assign adv     = tick_i & ~cnt_wr_i;
  assign match_a = adv && (cnt_o == cmp_a_i);
  assign match_b = adv && (cnt_o == cmp_b_i);
  assign wrap    = adv && (down_i ? (cnt_o == '0) : (cnt_o == '1));

  always_comb begin
    set_v         = '0;
    set_v[F_OVF]  = wrap;
    set_v[F_CMPA] = match_a;
    set_v[F_CMPB] = match_b;
    set_v[F_CAP]  = cap_evt_i;
    if (cnt_wr_i)               cnt_nx = cnt_wdata_i;
    else if (!adv)              cnt_nx = cnt_o;
    else if (match_a && clr_a_i) cnt_nx = '0;
    else if (down_i)            cnt_nx = cnt_o - 1'b1;
    else                        cnt_nx = cnt_o + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o       <= '0;
      cap_o       <= '0;
      flags_o     <= '0;
      cmp_a_pin_o <= 1'b0;
      cmp_b_pin_o <= 1'b0;
    end else begin
      cnt_o   <= cnt_nx;
      flags_o <= (flags_o & ~flag_clr_i) | set_v;
      if (cap_evt_i) cap_o <= cnt_o;
      if (match_a) cmp_a_pin_o <= ~cmp_a_pin_o;
      if (match_b) cmp_b_pin_o <= ~cmp_b_pin_o;
    end
  end
endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_cnt_i,
  input  logic              cap_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  output logic [NFLAG-1:0]  irq_o,
  output logic              cmp_a_o,
  output logic              cmp_b_o
);
  localparam int HI = CNT_W - 1;
  localparam int LO = BYTE_W;

  ctrl_t             ctrl_q;
  logic [NFLAG-1:0]  mask_q, flags_q, flag_clr;
  logic [BYTE_W-1:0] temp_q;
  logic [CNT_W-1:0]  cmp_a_q, cmp_b_q, cnt_q, cap_q;
  logic              ext_lvl, ext_prev, cap_lvl, cap_prev;
  logic              ext_rise, ext_fall, cap_evt, tick, cnt_wr;

  tmr_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk_i, .rst_ni, .d_i(ext_cnt_i), .lvl_o(ext_lvl), .prev_o(ext_prev)
  );
  tmr_sync #(.STAGES(SYNC_STAGES)) u_cap_sync (
    .clk_i, .rst_ni, .d_i(cap_i), .lvl_o(cap_lvl), .prev_o(cap_prev)
  );

  assign ext_rise = ext_lvl & ~ext_prev;
  assign ext_fall = ~ext_lvl & ext_prev;
  assign cap_evt  = cap_lvl & ~cap_prev;
  assign cnt_wr   = reg_we_i && (reg_addr_i == A_CNT_L);
  assign flag_clr = (reg_we_i && reg_addr_i == A_FLAGS) ? reg_wdata_i[NFLAG-1:0] : '0;

  tmr_tick_gen u_tick (
    .clk_i, .rst_ni, .src_i(ctrl_q.src), .psc_clr_i(cnt_wr),
    .ext_rise_i(ext_rise), .ext_fall_i(ext_fall), .tick_o(tick)
  );

  tmr_core u_core (
    .clk_i, .rst_ni, .tick_i(tick), .down_i(ctrl_q.down), .clr_a_i(ctrl_q.clr_a),
    .cnt_wr_i(cnt_wr), .cnt_wdata_i({temp_q, reg_wdata_i}),
    .cmp_a_i(cmp_a_q), .cmp_b_i(cmp_b_q), .cap_evt_i(cap_evt), .flag_clr_i(flag_clr),
    .cnt_o(cnt_q), .cap_o(cap_q), .flags_o(flags_q),
    .cmp_a_pin_o(cmp_a_o), .cmp_b_pin_o(cmp_b_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      mask_q  <= '0;
      temp_q  <= '0;
      cmp_a_q <= '0;
      cmp_b_q <= '0;
    end else if (reg_we_i) begin
      unique case (reg_addr_i)
        A_CTRL:   ctrl_q  <= ctrl_t'(reg_wdata_i[$bits(ctrl_t)-1:0]);
        A_MASK:   mask_q  <= reg_wdata_i[NFLAG-1:0];
        A_CMPA_L: cmp_a_q <= {temp_q, reg_wdata_i};
        A_CMPB_L: cmp_b_q <= {temp_q, reg_wdata_i};
        A_CNT_H, A_CMPA_H, A_CMPB_H: temp_q <= reg_wdata_i;
        default: ;
      endcase
    end else if (reg_re_i) begin
      unique case (reg_addr_i)
        A_CNT_L:  temp_q <= cnt_q[HI:LO];
        A_CMPA_L: temp_q <= cmp_a_q[HI:LO];
        A_CMPB_L: temp_q <= cmp_b_q[HI:LO];
        A_CAP_L:  temp_q <= cap_q[HI:LO];
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      A_CTRL:   reg_rdata_o = BYTE_W'(ctrl_q);
      A_FLAGS:  reg_rdata_o = BYTE_W'(flags_q);
      A_MASK:   reg_rdata_o = BYTE_W'(mask_q);
      A_CNT_L:  reg_rdata_o = cnt_q[LO-1:0];
      A_CMPA_L: reg_rdata_o = cmp_a_q[LO-1:0];
      A_CMPB_L: reg_rdata_o = cmp_b_q[LO-1:0];
      A_CAP_L:  reg_rdata_o = cap_q[LO-1:0];
      A_CNT_H, A_CMPA_H, A_CMPB_H, A_CAP_H: reg_rdata_o = temp_q;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign irq_o = flags_q & mask_q;
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             ext_rise_i,
  input logic             cnt_wr_i,
  input logic             down_i,
  input logic [2:0]       src_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] cap_i,
  input logic [NFLAG-1:0] flags_i,
  input logic [NFLAG-1:0] flag_clr_i
);
  p_stop_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == 3'd0 && !cnt_wr_i) |=> $stable(cnt_i));

  p_ext_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rise_i |=> !ext_rise_i);

  p_wrap_ovf_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cnt_wr_i && !down_i && cnt_i == '1) |=> flags_i[F_OVF]);

  p_cap_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cap_i) |-> flags_i[F_CAP]);

  p_flag_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flags_i & ~flag_clr_i) != '0) |=>
      ((flags_i & $past(flags_i & ~flag_clr_i)) == $past(flags_i & ~flag_clr_i)));
endmodule

bind cc_timer tmr_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .ext_rise_i(ext_rise),
  .cnt_wr_i(cnt_wr), .down_i(ctrl_q.down), .src_i(ctrl_q.src),
  .cnt_i(cnt_q), .cap_i(cap_q), .flags_i(flags_q), .flag_clr_i(flag_clr)
);

// File: tb/tb_cc_timer.sv
module tb_cc_timer;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       ext = 1'b0, cap = 1'b0, we = 1'b0, re = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [3:0] irq;
  logic       pa, pb;

  int checks = 0, errors = 0;
  string cur = "R1";

  cc_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .ext_cnt_i(ext), .cap_i(cap),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .cmp_a_o(pa), .cmp_b_o(pb)
  );

  always #2 clk = ~clk;

  // reference model
  int m_cnt, m_cap, m_cmpa, m_cmpb, m_temp, m_ctrl, m_mask, m_flags, m_psc, m_pa, m_pb;
  int e_sh, c_sh;

  function automatic int m_rd(int a);
    case (a)
      0: return m_ctrl;
      1: return m_flags;
      2: return m_mask;
      3: return m_cnt & 255;
      5: return m_cmpa & 255;
      7: return m_cmpb & 255;
      9: return m_cap & 255;
      4, 6, 8, 10: return m_temp;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", req, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_cap = 0; m_cmpa = 0; m_cmpb = 0; m_temp = 0; m_ctrl = 0;
      m_mask = 0; m_flags = 0; m_psc = 0; m_pa = 0; m_pb = 0; e_sh = 0; c_sh = 0;
    end else begin
      int src, tick, adv, setv, nxt, a, d, hi;
      bit er, ef, cr, down, wr;
      a = addr; d = wdata;
      er = e_sh[1] && !e_sh[2]; ef = !e_sh[1] && e_sh[2];
      cr = c_sh[1] && !c_sh[2];
      e_sh = ((e_sh << 1) | ext) & 7;
      c_sh = ((c_sh << 1) | cap) & 7;
      src = m_ctrl & 7; down = m_ctrl[3];
      case (src)
        0: tick = 0;
        1: tick = 1;
        2: tick = (m_psc % 8) == 7;
        3: tick = (m_psc % 64) == 63;
        4: tick = (m_psc % 256) == 255;
        5: tick = m_psc == 1023;
        6: tick = er;
        default: tick = ef;
      endcase
      wr = we && a == 3;
      adv = tick && !wr;
      setv = 0; nxt = m_cnt;
      if (cr) begin setv |= 8; m_cap = m_cnt; end
      if (wr) begin nxt = m_temp * 256 + d; m_psc = 0; end
      else begin
        m_psc = (m_psc + 1) % 1024;
        if (adv) begin
          if (m_cnt == m_cmpa) begin setv |= 2; m_pa ^= 1; end
          if (m_cnt == m_cmpb) begin setv |= 4; m_pb ^= 1; end
          if (down ? m_cnt == 0 : m_cnt == 65535) setv |= 1;
          if ((setv & 2) && m_ctrl[4]) nxt = 0;
          else nxt = down ? (m_cnt + 65535) % 65536 : (m_cnt + 1) % 65536;
        end
      end
      if (we && a == 1) m_flags &= ~(d & 15);
      m_flags |= setv;
      hi = m_temp;
      if (we) begin
        case (a)
          0: m_ctrl = d & 31;
          2: m_mask = d & 15;
          5: m_cmpa = m_temp * 256 + d;
          7: m_cmpb = m_temp * 256 + d;
          4, 6, 8: hi = d;
          default: ;
        endcase
      end else if (re) begin
        case (a)
          3: hi = m_cnt / 256;
          5: hi = m_cmpa / 256;
          7: hi = m_cmpb / 256;
          9: hi = m_cap / 256;
          default: ;
        endcase
      end
      m_temp = hi;
      m_cnt = nxt;
      #1;
      chk({cur, " irq"}, irq, m_flags & m_mask);
      chk({cur, " pins"}, {pa, pb}, {m_pa[0], m_pb[0]});
      chk({cur, " rdata"}, rdata, m_rd(addr));
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); we = 1; addr = 4'(a); wdata = 8'(d);
    @(negedge clk); we = 0;
  endtask
  task automatic wr16(int a, int v);
    wr(a + 1, v / 256); wr(a, v % 256);
  endtask
  task automatic rd(int a, output int v);
    @(negedge clk); re = 1; addr = 4'(a); #1 v = rdata;
    @(negedge clk); re = 0;
  endtask
  task automatic rd16(int a, output int v);
    int l, h;
    rd(a, l); rd(a + 1, h); v = h * 256 + l;
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse_ext();
    @(negedge clk); ext = 1; @(negedge clk); ext = 0; @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    #9 rst_n = 1'b1;
    // R1 reset state
    cur = "R1";
    for (int a = 0; a < 11; a++) begin rd(a, v); chk("R1 reg", v, 0); end
    chk("R1 irq", irq, 0);
    chk("R1 pins", {pa, pb}, 0);

    // R2 stopped source holds; R10 staging without commit
    cur = "R2";
    wr16(3, 16'h1234); idle(6); rd16(3, v); chk("R2 stop hold", v, 16'h1234);
    cur = "R10";
    wr(4, 8'hAB); idle(2); rd16(3, v); chk("R10 staged only", v, 16'h1234);
    wr(9, 8'h55); wr(10, 8'h66); rd16(9, v); chk("R10 cap write ignored", v, 0);
    rd(15, v); chk("R10 unused addr", v, 0);

    // R6 compare at both ends of the range
    cur = "R6";
    wr16(5, 16'hFFFF); wr16(7, 16'h0000); wr16(3, 16'hFFFD);
    wr(2, 4'h7); wr(0, 1); idle(8); wr(0, 0);
    rd(1, v); chk("R6 flags cmpA/cmpB/ovf", v, 7);
    chk("R6 pins toggled", {pa, pb}, 2'b11);
    cur = "R9";
    chk("R9 irq gated", irq, 7);
    wr(1, 2); rd(1, v); chk("R9 w1c cmpA", v, 5);
    wr(2, 4'h4); chk("R9 irq mask", irq, 4);
    wr(1, 15);

    // R5 down count and underflow
    cur = "R5";
    wr16(3, 2); wr(0, 8'h09); idle(6); wr(0, 0);
    rd(1, v); chk("R5 down wrap flag", v & 1, 1);
    wr(1, 15);

    // R3 prescaler variants
    cur = "R3";
    for (int s = 2; s <= 5; s++) begin
      wr16(3, 0); wr(0, s); idle(2100); wr(0, 0);
      rd16(3, v); chk("R3 divided count", v, m_cnt);
    end

    // R4 external edges
    cur = "R4";
    wr16(3, 0); wr(0, 6);
    for (int i = 0; i < 5; i++) pulse_ext();
    idle(4); rd16(3, v); chk("R4 rising count", v, 5);
    wr(0, 7);
    for (int i = 0; i < 5; i++) pulse_ext();
    idle(4); rd16(3, v); chk("R4 falling count", v, 10);
    wr(0, 0);

    // R7 clear on compare A
    cur = "R7";
    wr(1, 15); wr16(5, 3); wr16(3, 0); wr(0, 8'h11); idle(20); wr(0, 0);
    rd16(3, v); chk("R7 bounded", (v <= 3) ? 1 : 0, 1);
    rd(1, v); chk("R7 no ovf", v & 1, 0);

    // R8 capture on the overflow cycle
    cur = "R8";
    wr16(5, 16'h0100); wr(1, 15); wr16(3, 16'hFFFD);
    @(negedge clk); we = 1; addr = 0; wdata = 1;
    @(negedge clk); we = 0; cap = 1;
    idle(6); wr(0, 0); cap = 0;
    rd16(9, v); chk("R8 capture value", v, 16'hFFFF);
    rd(1, v); chk("R8 cap+ovf flags", v & 9, 9);

    idle(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule